// File: doc/BRIEF.md
# USB IN Transfer Packetizer

This block breaks one device-to-host transfer of a given byte length into a series of USB packets for one endpoint. Software (or a sequencer) hands it a buffer base address, a length, the endpoint kind and the bus speed. For every packet the block waits until the endpoint's transmit buffer has room, strobes out the packet size, then the packet address, then a DMA start, and finally a pulse that lets the endpoint stop answering the host with NAK. It then waits for the host's acknowledge before moving on.

The remaining byte count is kept as a signed number and always drops by a whole max packet size per packet, even when the packet was short. An acknowledge that finds the count at zero or above sends another packet. A count of exactly zero gives a zero-length packet, which marks the end of a transfer whose length is a whole number of max packets. An acknowledge that finds the count negative finishes the transfer with a done pulse. A transmit buffer that stays full too long is given up on after a bounded wait, and a sticky error flag records the event.

Top module: `usb_in_pktzr`

## Requirements
- R1: The max packet size follows the endpoint kind code `ep_kind_i` and `high_speed_i`: code 0 (control) gives 64 at either speed, code 1 (bulk) gives 512 at high speed and 64 at full speed, code 2 (interrupt) gives 1024 at high speed and 64 at full speed, and code 3 is treated as control.
- R2: Each packet size equals the smaller of the remaining count and the max packet size. The first packet address equals the base address, and every later address is the previous address plus the previous packet size.
- R3: After each packet the remaining count drops by the full max packet size. An acknowledge with the count at zero or above issues one more packet, which is zero-length when the count is exactly zero. So a length of zero or a whole multiple of the max packet size ends with a zero-length packet, and a transfer of length L has L / max + 1 packets.
- R4: Each packet is loaded as four one-cycle pulses on four consecutive cycles: `pkt_size_we_o`, then `pkt_addr_we_o`, then `dma_start_o`, then `nak_release_o`. At most one of these pulses and `done_o` is high in any cycle.
- R5: While `txbuf_full_i` is high, no packet is loaded until the wait limit is reached. When the flag is low, loading starts on the next cycle.
- R6: If `txbuf_full_i` stays high for `TMO_CYC` consecutive waiting cycles, the packet is loaded anyway and `timeout_err_o` is set. The flag stays set until the next accepted start. If the flag drops on the very cycle the limit is reached, no error is raised.
- R7: A start pulse while busy, including the done cycle, is ignored. An acknowledge is ignored unless the block is waiting for one, and that includes acknowledges while idle.
- R8: `done_o` pulses for exactly one cycle after the acknowledge that finds the count negative, and `busy_o` is low on the following cycle.
- R9: After reset all pulses, `busy_o` and `timeout_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (accepted only when idle) |
| base_addr_i | input | ADDR_W | Buffer base address |
| length_i | input | LEN_W | Transfer length in bytes |
| ep_kind_i | input | 2 | 0 control, 1 bulk, 2 interrupt, 3 treated as control |
| high_speed_i | input | 1 | 1 for high-speed bus, 0 for full speed |
| ack_i | input | 1 | Host acknowledged the last packet |
| txbuf_full_i | input | 1 | Endpoint transmit buffer is full |
| pkt_size_o | output | 11 | Size of the current packet |
| pkt_size_we_o | output | 1 | Size load pulse |
| pkt_addr_o | output | ADDR_W | Address of the current packet |
| pkt_addr_we_o | output | 1 | Address load pulse |
| dma_start_o | output | 1 | DMA start pulse |
| nak_release_o | output | 1 | Release NAK so the endpoint answers the host |
| done_o | output | 1 | Transfer finished pulse |
| timeout_err_o | output | 1 | Sticky flag: buffer wait timed out |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The wait timer's expiry and the buffer-full flag dropping can fall on the same cycle. The bench holds the flag high for exactly `TMO_CYC - 1` waiting cycles and then, in a second run, for `TMO_CYC`. It expects the first size pulse on a precomputed cycle in both runs, and an error flag only in the second. A start pulse driven in the same cycle as `done_o` also collides with the return to idle. The bench expects it to be dropped, with `busy_o` low on the next cycle.

// File: rtl/usb_in_pktzr_pkg.sv
package usb_in_pktzr_pkg;

  typedef logic [10:0] mps_t;

  typedef enum logic [1:0] {
    EP_CTRL = 2'd0,
    EP_BULK = 2'd1,
    EP_INTR = 2'd2,
    EP_RSVD = 2'd3
  } ep_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_SIZE,
    S_ADDR,
    S_DMA,
    S_NAK,
    S_ACK,
    S_DONE
  } pk_state_e;

  // Largest packet the endpoint kind may carry at the given speed.
  function automatic mps_t mps_for(input logic [1:0] kind, input logic hs);
    mps_t m;
    case (kind)
      EP_BULK: m = hs ? mps_t'(512)  : mps_t'(64);
      EP_INTR: m = hs ? mps_t'(1024) : mps_t'(64);
      default: m = mps_t'(64);
    endcase
    return m;
  endfunction

  // Packet size: remaining bytes capped at the max packet size.
  function automatic mps_t clip_size(input longint rem, input mps_t m);
    mps_t s;
    if (rem <= 0)
      s = '0;
    else if (rem > longint'(m))
      s = m;
    else
      s = mps_t'(rem);
    return s;
  endfunction

endpackage

// File: rtl/usb_in_pktzr_bufwait.sv
module usb_in_pktzr_bufwait #(
  parameter int TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic full_i,
  output logic go_o,
  output logic expire_o
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(TMO_CYC - 1));
  assign expire_o = arm_i && full_i && at_limit;
  assign go_o     = arm_i && (!full_i || at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!arm_i || go_o)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/usb_in_pktzr_track.sv
module usb_in_pktzr_track
  import usb_in_pktzr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int REM_W  = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [LEN_W-1:0]        len_i,
  input  mps_t                    mps_i,
  input  logic                    step_i,
  output logic signed [REM_W-1:0] rem_o,
  output logic [ADDR_W-1:0]       addr_o,
  output mps_t                    size_o,
  output logic                    more_o
);
  logic signed [REM_W-1:0] rem_q;
  logic [ADDR_W-1:0]       addr_q;
  logic signed [REM_W-1:0] mps_s;

  assign mps_s  = $signed({{(REM_W-11){1'b0}}, mps_i});
  assign size_o = clip_size(longint'(rem_q), mps_i);
  assign more_o = !rem_q[REM_W-1];
  assign rem_o  = rem_q;
  assign addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      rem_q  <= $signed({{(REM_W-LEN_W){1'b0}}, len_i});
      addr_q <= base_i;
    end else if (step_i) begin
      rem_q  <= rem_q - mps_s;
      addr_q <= addr_q + {{(ADDR_W-11){1'b0}}, size_o};
    end
  end
endmodule

// File: rtl/usb_in_pktzr.sv
module usb_in_pktzr
  import usb_in_pktzr_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int TMO_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [LEN_W-1:0]  length_i,
  input  logic [1:0]        ep_kind_i,
  input  logic              high_speed_i,
  input  logic              ack_i,
  input  logic              txbuf_full_i,
  output logic [10:0]       pkt_size_o,
  output logic              pkt_size_we_o,
  output logic [ADDR_W-1:0] pkt_addr_o,
  output logic              pkt_addr_we_o,
  output logic              dma_start_o,
  output logic              nak_release_o,
  output logic              done_o,
  output logic              timeout_err_o,
  output logic              busy_o
);
  localparam int BASE_W = (LEN_W > 11) ? LEN_W : 11;
  localparam int REM_W  = BASE_W + 2;

  pk_state_e state_q, state_d;
  mps_t      mps_q;
  logic      err_q;

  // Named internal events
  logic                    start_ok;
  logic                    wait_armed;
  logic                    wait_go;
  logic                    wait_expire;
  logic                    step_ev;
  logic                    ack_ev;
  logic                    more_pkts;
  logic signed [REM_W-1:0] rem_now;
  mps_t                    size_now;
  logic [ADDR_W-1:0]       addr_now;

  assign start_ok   = (state_q == S_IDLE) && start_i;
  assign wait_armed = (state_q == S_WAIT);
  assign step_ev    = (state_q == S_NAK);
  assign ack_ev     = (state_q == S_ACK) && ack_i;

  usb_in_pktzr_bufwait #(
    .TMO_CYC (TMO_CYC)
  ) wait_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (wait_armed),
    .full_i   (txbuf_full_i),
    .go_o     (wait_go),
    .expire_o (wait_expire)
  );

  usb_in_pktzr_track #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .REM_W  (REM_W)
  ) track_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_ok),
    .base_i (base_addr_i),
    .len_i  (length_i),
    .mps_i  (mps_q),
    .step_i (step_ev),
    .rem_o  (rem_now),
    .addr_o (addr_now),
    .size_o (size_now),
    .more_o (more_pkts)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_WAIT;
      S_WAIT: if (wait_go) state_d = S_SIZE;
      S_SIZE: state_d = S_ADDR;
      S_ADDR: state_d = S_DMA;
      S_DMA:  state_d = S_NAK;
      S_NAK:  state_d = S_ACK;
      S_ACK:  if (ack_i) state_d = more_pkts ? S_WAIT : S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mps_q   <= mps_t'(64);
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) begin
        mps_q <= mps_for(ep_kind_i, high_speed_i);
        err_q <= 1'b0;
      end else if (wait_expire) begin
        err_q <= 1'b1;
      end
    end
  end

  assign pkt_size_o    = size_now;
  assign pkt_addr_o    = addr_now;
  assign pkt_size_we_o = (state_q == S_SIZE);
  assign pkt_addr_we_o = (state_q == S_ADDR);
  assign dma_start_o   = (state_q == S_DMA);
  assign nak_release_o = (state_q == S_NAK);
  assign done_o        = (state_q == S_DONE);
  assign timeout_err_o = err_q;
  assign busy_o        = (state_q != S_IDLE);
endmodule

// File: rtl/usb_in_pktzr_chk.sv
module usb_in_pktzr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        ack_i,
  input logic        txbuf_full_i,
  input logic [10:0] pkt_size_o,
  input logic        pkt_size_we_o,
  input logic        pkt_addr_we_o,
  input logic        dma_start_o,
  input logic        nak_release_o,
  input logic        done_o,
  input logic        timeout_err_o,
  input logic        busy_o,
  input logic        wait_armed,
  input logic        wait_expire,
  input logic [10:0] mps_q
);
  p_size_then_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_size_we_o |=> pkt_addr_we_o);
  p_addr_then_dma_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_addr_we_o |=> dma_start_o);
  p_dma_then_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start_o |=> nak_release_o);
  p_pulses_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_size_we_o, pkt_addr_we_o, dma_start_o, nak_release_o, done_o}));
  p_size_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_size_we_o |-> (pkt_size_o <= mps_q));
  p_hold_while_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_armed && txbuf_full_i && !wait_expire) |=> !pkt_size_we_o);
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err_o) |-> $past(wait_expire));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  p_start_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !busy_o);
  p_ack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && ack_i && !start_i) |=> !busy_o);
endmodule

bind usb_in_pktzr usb_in_pktzr_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .ack_i         (ack_i),
  .txbuf_full_i  (txbuf_full_i),
  .pkt_size_o    (pkt_size_o),
  .pkt_size_we_o (pkt_size_we_o),
  .pkt_addr_we_o (pkt_addr_we_o),
  .dma_start_o   (dma_start_o),
  .nak_release_o (nak_release_o),
  .done_o        (done_o),
  .timeout_err_o (timeout_err_o),
  .busy_o        (busy_o),
  .wait_armed    (wait_armed),
  .wait_expire   (wait_expire),
  .mps_q         (mps_q)
);

// File: tb/usb_in_pktzr_tb_top.sv
module usb_in_pktzr_tb_top;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int TMO    = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic [LEN_W-1:0]  length_i = '0;
  logic [1:0]        ep_kind_i = '0;
  logic              high_speed_i = 1'b0;
  logic              ack_i = 1'b0;
  logic              txbuf_full_i = 1'b0;
  logic [10:0]       pkt_size_o;
  logic              pkt_size_we_o;
  logic [ADDR_W-1:0] pkt_addr_o;
  logic              pkt_addr_we_o;
  logic              dma_start_o;
  logic              nak_release_o;
  logic              done_o;
  logic              timeout_err_o;
  logic              busy_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  usb_in_pktzr #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .TMO_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .length_i(length_i), .ep_kind_i(ep_kind_i), .high_speed_i(high_speed_i),
    .ack_i(ack_i), .txbuf_full_i(txbuf_full_i), .pkt_size_o(pkt_size_o),
    .pkt_size_we_o(pkt_size_we_o), .pkt_addr_o(pkt_addr_o),
    .pkt_addr_we_o(pkt_addr_we_o), .dma_start_o(dma_start_o),
    .nak_release_o(nak_release_o), .done_o(done_o),
    .timeout_err_o(timeout_err_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int bench_mps(input logic [1:0] k, input bit hs);
    if (k == 2'd1) return hs ? 512 : 64;
    if (k == 2'd2) return hs ? 1024 : 64;
    return 64;
  endfunction

  // One full transfer with expected packet list worked out in the bench.
  task automatic run_xfer(input logic [1:0] kind, input bit hs,
                          input logic [31:0] base, input int len,
                          input int full_cyc, input bit poke,
                          input bit exp_err, input string rq);
    int mps, rem, exp_sz, n_exp, n_got, cyc, last, ack_dly, first_sz, exp_first, lim;
    logic [31:0] a;
    bit fin;
    mps = bench_mps(kind, hs);
    rem = len; a = base; n_exp = len / mps + 1; n_got = 0; cyc = 0;
    last = -10; ack_dly = 0; fin = 0; first_sz = -1; exp_sz = 0;
    lim = (full_cyc < 1) ? 1 : full_cyc;
    exp_first = ((lim < TMO) ? lim : TMO) + 1;
    if (poke) begin
      @(negedge clk); ack_i = 1'b1;          // R7: ack while idle
      @(negedge clk); ack_i = 1'b0;
      chk(!busy_o && !pkt_size_we_o, "R7", "ack while idle", busy_o, 0);
    end
    @(negedge clk);
    ep_kind_i = kind; high_speed_i = hs; base_addr_i = base;
    length_i = LEN_W'(len); start_i = 1'b1;
    while (!fin && cyc < 20000) begin
      @(negedge clk); cyc++;
      start_i = 1'b0;
      txbuf_full_i = (cyc < full_cyc);
      ack_i = 1'b0;
      if (ack_dly > 0) begin ack_dly--; if (ack_dly == 0) ack_i = 1'b1; end
      if (cyc == 1)
        chk(timeout_err_o == 1'b0, "R6", "error cleared by start", timeout_err_o, 0);
      if (poke && cyc == 3) begin
        start_i = 1'b1; base_addr_i = 32'hDEAD0000; length_i = LEN_W'(5); // R7
      end
      if (pkt_size_we_o) begin
        if (first_sz < 0) begin
          first_sz = cyc;
          chk(cyc == exp_first, "R5", "first size cycle", cyc, exp_first);
        end
        exp_sz = (rem > mps) ? mps : rem;
        chk(rem >= 0, "R3", "no extra packet", rem, 0);
        chk(pkt_size_o == exp_sz, "R2", "packet size", pkt_size_o, exp_sz);
        last = cyc; n_got++;
      end
      if (pkt_addr_we_o) begin
        chk(cyc == last + 1, "R4", "addr after size", cyc, last + 1);
        chk(pkt_addr_o == a, "R2", "packet address", pkt_addr_o, a);
      end
      if (dma_start_o) chk(cyc == last + 2, "R4", "dma after addr", cyc, last + 2);
      if (nak_release_o) begin
        chk(cyc == last + 3, "R4", "nak after dma", cyc, last + 3);
        a = a + exp_sz; rem = rem - mps; ack_dly = 1;
        if (poke) ack_i = 1'b1;               // R7: early ack, ignored
      end
      if (done_o) begin
        fin = 1;
        if (poke) start_i = 1'b1;             // R7: start in done cycle
      end
    end
    chk(fin, rq, "done seen", fin, 1);
    chk(n_got == n_exp, "R3", "packet count", n_got, n_exp);
    chk(rem < 0, "R3", "final remainder negative", rem, -1);
    @(negedge clk);
    start_i = 1'b0;
    chk(!busy_o && !done_o, "R8", "idle after done", busy_o, 0);
    chk(timeout_err_o == exp_err, "R6", "timeout flag", timeout_err_o, exp_err);
    @(negedge clk);
    chk(!busy_o, "R7", "start at done dropped", busy_o, 0);
  endtask

  task automatic t_reset;
    chk(!pkt_size_we_o && !pkt_addr_we_o && !dma_start_o && !nak_release_o &&
        !done_o && !busy_o && !timeout_err_o, "R9", "reset outputs",
        {pkt_size_we_o, pkt_addr_we_o, dma_start_o, nak_release_o, done_o,
         busy_o, timeout_err_o}, 0);
  endtask

  task automatic t_ctrl;      run_xfer(2'd0, 1, 32'h1000, 100, 0, 0, 0, "R1"); endtask
  task automatic t_bulk_hs;   run_xfer(2'd1, 1, 32'h2000, 1024, 0, 0, 0, "R3"); endtask
  task automatic t_bulk_fs;   run_xfer(2'd1, 0, 32'h3000, 130, 0, 0, 0, "R1"); endtask
  task automatic t_intr_hs;   run_xfer(2'd2, 1, 32'h4000, 1500, 0, 0, 0, "R1"); endtask
  task automatic t_intr_fs;   run_xfer(2'd2, 0, 32'h5000, 64, 0, 0, 0, "R3"); endtask
  task automatic t_zero_len;  run_xfer(2'd1, 1, 32'h6000, 0, 0, 0, 0, "R3"); endtask
  task automatic t_kind3;     run_xfer(2'd3, 1, 32'h7000, 70, 0, 0, 0, "R1"); endtask
  task automatic t_full_wait; run_xfer(2'd1, 1, 32'h8000, 600, 7, 0, 0, "R5"); endtask
  task automatic t_edge_ok;   run_xfer(2'd0, 0, 32'h9000, 10, TMO, 0, 0, "R6"); endtask
  task automatic t_timeout;   run_xfer(2'd0, 0, 32'hA000, 10, TMO + 1, 0, 1, "R6"); endtask
  task automatic t_clear_err; run_xfer(2'd1, 0, 32'hB000, 64, 0, 0, 0, "R6"); endtask
  task automatic t_ignored;   run_xfer(2'd1, 1, 32'hC000, 700, 0, 1, 0, "R7"); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_bulk_hs();
    t_bulk_fs();
    t_intr_hs();
    t_intr_fs();
    t_zero_len();
    t_kind3();
    t_full_wait();
    t_edge_ok();
    t_timeout();
    t_clear_err();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule